// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block turns nine active-low interrupt inputs into clean request signals for a downstream priority controller. Eight of them are ordinary interrupt lines and one is a fast-interrupt line. Every input goes through a synchroniser before any decision is made. A falling edge or a low level then raises a request, depending on the configuration.

Each ordinary line has a configuration bit that selects its trigger. With falling-edge triggering, the line sets a sticky flag that software clears by writing a 1. With low-level triggering, the request simply tracks the synchronised input. The fast line is always edge triggered and has its own mask bit. A stop-mode input overrides all of this: while it is high, every line, the fast one included, reports its synchronised low level.

The register interface has four word addresses:
- 0 is the trigger-mode vector.
- 1 is the fast mask in bit 0.
- 2 is the write-one-to-clear register for the ordinary flags.
- 3 is the write-one-to-clear register for the fast flag, in bit 0.

Top module: `ext_irq_cond`

## Requirements
- R1: Each input passes through a two-stage synchroniser. A single falling edge is latched once only, so a flag that is cleared while its input stays low remains clear.
- R2: With mode bit i = 0 (edge), a falling edge on `extIrqN[i]` sets `irqReq[i]`. The request stays set after the input returns high.
- R3: Writing address 2 clears flag i for every data bit i that is 1. Flags whose data bit is 0 are unchanged.
- R4: When a clear of flag i and a new edge on input i land in the same cycle, the flag ends up set. A clear of another flag in that same write still takes effect.
- R5: With mode bit i = 1 (level), `irqReq[i]` equals the inverted synchronised input. A write of 1 to clear bit i does not change it.
- R6: With mask = 0, a falling edge on `fastIrqN` sets `fastReq`. It stays set until a write to address 3 with bit 0 = 1.
- R7: With mask = 1, `fastReq` is 0. A fast edge that arrives while masked is not latched, and a flag latched earlier becomes visible again when the mask is cleared.
- R8: While `stopMode` = 1, `irqReq` equals the inverted synchronised inputs for all eight lines, whatever the mode bits say. `fastReq` equals the inverted synchronised fast input gated by the mask. Edge flags keep latching underneath and reappear when stop mode ends.
- R9: After reset, all mode bits are 0 (edge), the mask is 1, and both `irqReq` and `fastReq` are 0.
- R10: `regRdData` returns the mode vector at address 0 and the mask in bit 0 at address 1. It returns zero at addresses 2 and 3. A write to address 0 or 1 is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIrqN | input | NUM_IRQ | Ordinary interrupt inputs, active low, asynchronous |
| fastIrqN | input | 1 | Fast interrupt input, active low, asynchronous |
| stopMode | input | 1 | Forces level triggering on every input while high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | NUM_IRQ | Register write data |
| regRdData | output | NUM_IRQ | Register read data (combinational) |
| irqReq | output | NUM_IRQ | Ordinary request flags, active high |
| fastReq | output | 1 | Fast request, active high |

## Verification
The embedded assertions cover the cycle-level invariants on every cycle:
- an edge pulse never lasts two cycles;
- an uncleared edge flag never drops;
- an edge always wins over a simultaneous clear;
- the fast flag only rises while unmasked;
- the control decode never issues two strobes at once.

The end-to-end mappings need the bench's sweeps, because they depend on input history across many cycles. These are level tracking for all 256 input patterns under several mode vectors, the stop-mode override, and flags that survive mode and stop transitions.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_MODE  = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_CLR   = 2'd2,
    ADDR_FCLR  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic wrMode;
    logic wrMask;
    logic clrIrq;
    logic clrFast;
  } ctrlStrb_t;
endpackage

// File: rtl/eic_sync.sv
`timescale 1ns/1ps
module eic_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '1;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '1;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/eic_ctrl.sv
`timescale 1ns/1ps
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_IRQ-1:0]    modeReg,
  input  logic                  maskReg,
  output ctrlStrb_t             strb,
  output logic [NUM_IRQ-1:0]    regRdData
);
  regAddr_e addrDec;
  assign addrDec = regAddr_e'(regAddr);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (addrDec)
        ADDR_MODE: strb.wrMode  = 1'b1;
        ADDR_MASK: strb.wrMask  = 1'b1;
        ADDR_CLR:  strb.clrIrq  = 1'b1;
        ADDR_FCLR: strb.clrFast = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (addrDec)
      ADDR_MODE: regRdData = modeReg;
      ADDR_MASK: regRdData[0] = maskReg;
      default:   regRdData = '0;
    endcase
  end

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMode, strb.wrMask, strb.clrIrq, strb.clrFast})); // R3

  AST_NO_STRB_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strb == '0)); // R10
endmodule

// File: rtl/eic_datapath.sv
`timescale 1ns/1ps
module eic_datapath
  import eic_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] extIrqN,
  input  logic               fastIrqN,
  input  logic               stopMode,
  input  ctrlStrb_t          strb,
  input  logic [NUM_IRQ-1:0] wrData,
  output logic [NUM_IRQ-1:0] irqReq,
  output logic               fastReq,
  output logic [NUM_IRQ-1:0] modeReg,
  output logic               maskReg
);
  localparam int LINES = NUM_IRQ + 1;
  localparam int FAST  = NUM_IRQ;

  logic [LINES-1:0]   rawSync;
  logic [LINES-1:0]   prevSync;
  logic [LINES-1:0]   lowNow;
  logic [LINES-1:0]   fallPulse;
  logic [NUM_IRQ-1:0] irqFlag, irqFlagNext;
  logic               fastFlag, fastFlagNext;
  logic [NUM_IRQ-1:0] levelSel;
  logic               fastClrHit;

  eic_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({fastIrqN, extIrqN}),
    .syncOut (rawSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSync <= '1;
    else       prevSync <= rawSync;
  end

  assign lowNow    = ~rawSync;
  assign fallPulse = prevSync & ~rawSync;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      maskReg <= 1'b1;
    end else begin
      if (strb.wrMode) modeReg <= wrData;
      if (strb.wrMask) maskReg <= wrData[0];
    end
  end

  // per-line sticky edge flags; a new edge outranks a clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic clrHit;
    assign clrHit         = strb.clrIrq & wrData[i];
    assign irqFlagNext[i] = (fallPulse[i] & ~modeReg[i]) | (irqFlag[i] & ~clrHit);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      fallPulse[i] |=> !fallPulse[i]); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlag[i] && !clrHit) |=> irqFlag[i]); // R2

    AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (fallPulse[i] && !modeReg[i] && clrHit) |=> irqFlag[i]); // R4
  end

  assign fastClrHit   = strb.clrFast & wrData[0];
  assign fastFlagNext = (fallPulse[FAST] & ~maskReg) | (fastFlag & ~fastClrHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag  <= '0;
      fastFlag <= 1'b0;
    end else begin
      irqFlag  <= irqFlagNext;
      fastFlag <= fastFlagNext;
    end
  end

  assign levelSel = modeReg | {NUM_IRQ{stopMode}};
  assign irqReq   = (levelSel & lowNow[NUM_IRQ-1:0]) | (~levelSel & irqFlag);
  assign fastReq  = ~maskReg & (stopMode ? lowNow[FAST] : fastFlag);

  AST_FAST_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fastFlag) |-> !$past(maskReg)); // R7

  AST_FAST_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (fastClrHit && !fallPulse[FAST]) |=> !fastFlag); // R6

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMode |=> (modeReg == $past(wrData))); // R10
endmodule

// File: rtl/ext_irq_cond.sv
`timescale 1ns/1ps
module ext_irq_cond
  import eic_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_IRQ-1:0]    extIrqN,
  input  logic                  fastIrqN,
  input  logic                  stopMode,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [NUM_IRQ-1:0]    regWrData,
  output logic [NUM_IRQ-1:0]    regRdData,
  output logic [NUM_IRQ-1:0]    irqReq,
  output logic                  fastReq
);
  ctrlStrb_t          strb;
  logic [NUM_IRQ-1:0] modeReg;
  logic               maskReg;

  eic_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .modeReg   (modeReg),
    .maskReg   (maskReg),
    .strb      (strb),
    .regRdData (regRdData)
  );

  eic_datapath #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .extIrqN  (extIrqN),
    .fastIrqN (fastIrqN),
    .stopMode (stopMode),
    .strb     (strb),
    .wrData   (regWrData),
    .irqReq   (irqReq),
    .fastReq  (fastReq),
    .modeReg  (modeReg),
    .maskReg  (maskReg)
  );
endmodule

// File: tb/ext_irq_cond_bench.sv
`timescale 1ns/1ps
module ext_irq_cond_bench;
  localparam int N = 8;
  localparam real HALF = 2.5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] extIrqN = '1;
  logic         fastIrqN = 1'b1;
  logic         stopMode = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic [N-1:0] irqReq;
  logic         fastReq;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [N-1:0] mMode = '0;
  logic         mMask = 1'b1;
  logic [N-1:0] mFlag = '0;
  logic         mFast = 1'b0;
  logic [N-1:0] curIn = '1;
  logic         curFast = 1'b1;

  always #(HALF) clk = ~clk;

  ext_irq_cond #(.NUM_IRQ(N)) u_ext_irq_cond (
    .clk(clk), .rstN(rstN), .extIrqN(extIrqN), .fastIrqN(fastIrqN),
    .stopMode(stopMode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .fastReq(fastReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] p, input logic f);
    mFlag = mFlag | (curIn & ~p & ~mMode);
    if (curFast && !f && !mMask) mFast = 1'b1;
    @(negedge clk);
    extIrqN = p; fastIrqN = f;
    curIn = p; curFast = f;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      2'd0: mMode = d;
      2'd1: mMask = d[0];
      2'd2: mFlag = mFlag & ~d;
      default: if (d[0]) mFast = 1'b0;
    endcase
  endtask

  task automatic expectOut(input string tag);
    logic [N-1:0] lvl;
    logic [N-1:0] eIrq;
    logic         eFast;
    lvl   = mMode | {N{stopMode}};
    eIrq  = (lvl & ~curIn) | (~lvl & mFlag);
    eFast = !mMask && (stopMode ? !curFast : mFast);
    chk({tag, " irqReq"}, 32'(irqReq), 32'(eIrq));
    chk({tag, " fastReq"}, 32'(fastReq), 32'(eFast));
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(tag, 32'(regRdData), 32'(exp));
  endtask

  initial begin
    #(2.0 * HALF * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irqReq", 32'(irqReq), 0);
    chk("R9 fastReq", 32'(fastReq), 0);
    rd("R9 mode", 2'd0, '0);
    rd("R9 mask", 2'd1, 8'h01);

    // R2 edge sweep, one line at a time
    for (int i = 0; i < N; i++) begin
      apply(~(8'h01 << i), 1'b1);
      apply('1, 1'b1);
      expectOut("R2");
    end

    // R1 one edge latched once: clear while still low
    wr(2'd2, '1);
    apply(8'hFE, 1'b1);
    wr(2'd2, 8'h01);
    repeat (5) @(negedge clk);
    expectOut("R1");
    apply('1, 1'b1);
    expectOut("R1");

    // R3 partial clears
    apply('0, 1'b1);
    apply('1, 1'b1);
    wr(2'd2, 8'h5A);
    expectOut("R3");
    wr(2'd2, '1);
    expectOut("R3");

    // R4 clear and new edge on line 3 in the same cycle; line 6 cleared
    apply(8'hBF, 1'b1);
    apply('1, 1'b1);
    @(negedge clk);
    extIrqN = 8'hF7;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 8'h48;
    @(negedge clk);
    regWrEn = 1'b0;
    mFlag = (mFlag & ~8'h48) | 8'h08;
    curIn = 8'hF7;
    repeat (2) @(negedge clk);
    expectOut("R4");
    apply('1, 1'b1);
    expectOut("R4");

    // R5 level mode, all lines, full pattern sweep
    wr(2'd2, '1);
    wr(2'd0, '1);
    for (int p = 0; p < 256; p++) begin
      apply(8'(p), 1'b1);
      expectOut("R5");
    end
    apply('0, 1'b1);
    wr(2'd2, '1);
    expectOut("R5");
    // R5 mixed modes
    wr(2'd0, 8'hA5);
    for (int p = 0; p < 256; p += 3) begin
      apply(8'(p ^ 8'h3C), 1'b1);
      expectOut("R5");
    end
    apply('1, 1'b1);
    wr(2'd0, '0);
    wr(2'd2, '1);
    expectOut("R5");

    // R7 masked fast edge ignored, R6 unmasked edge latched
    apply('1, 1'b0);
    apply('1, 1'b1);
    expectOut("R7");
    wr(2'd1, 8'h00);
    expectOut("R7");
    apply('1, 1'b0);
    apply('1, 1'b1);
    expectOut("R6");
    wr(2'd1, 8'h01);
    expectOut("R7");
    wr(2'd1, 8'h00);
    expectOut("R7");
    wr(2'd3, 8'h01);
    expectOut("R6");

    // R8 stop mode overrides edge configuration
    @(negedge clk);
    stopMode = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      apply(8'(k * 37 + 5), 1'(k));
      expectOut("R8");
    end
    wr(2'd1, 8'h01);
    apply('1, 1'b0);
    expectOut("R8");
    wr(2'd1, 8'h00);
    expectOut("R8");
    apply('1, 1'b1);
    @(negedge clk);
    stopMode = 1'b0;
    @(negedge clk);
    expectOut("R8");

    // R10 register readback
    wr(2'd0, 8'h3C);
    rd("R10 mode", 2'd0, 8'h3C);
    rd("R10 mask", 2'd1, 8'h00);
    rd("R10 clr", 2'd2, 8'h00);
    rd("R10 fclr", 2'd3, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule